// File: doc/BRIEF.md
# Clock-Synchronous Burst Transmitter with Programmable Inter-Byte Gap

This block shifts bytes out on a serial clock and serial data pair that it generates itself from the system clock. Once a start command arrives, it keeps taking bytes from a valid/ready source and sends them one after another. After every byte it holds the line idle for a programmed number of transfer-clock periods before it offers to take the next byte. When the gap ends and no byte is waiting, the burst ends and the block goes idle.

An 8-bit control word sets the transfer clock. The upper three bits pick the ratio to the system clock, and the lower five bits encode the gap length. At each control write, the block converts the programmed gap into system clocks. It compares the result with the minimum that the selected operating mode needs and flags a gap that is too short. Divider codes with no defined ratio are flagged as well, and the block runs them at the fastest legal ratio.

Top module: `sync_burst_tx`

## Requirements
- R1: Control bits 7:5 set the transfer-clock period N in system clocks: 000 gives N=4, 001 gives N=8 and 010 gives N=16. Every data bit lasts N system clocks, with `sclk` low for N/2 clocks and then high for N/2 clocks.
- R2: Divider codes 011 to 111 run with N=4. They set `div_err` one cycle after the write. The next write with a legal code clears it.
- R3: Bytes leave least significant bit first. `sdo` changes only in the cycle where `sclk` falls, and it is stable while `sclk` is high.
- R4: Control bits 4:0 hold a code k. After the last bit of a byte, `sclk` stays high for (k+2)*N system clocks of gap, plus one handshake cycle. With bytes back to back, the high run between bytes is therefore N/2+(k+2)*N+1 clocks.
- R5: `sclk` idles high and does not toggle while `busy` is low or during a gap.
- R6: One cycle after a control write, `gap_err` equals ((k+2)*N < M). M is chosen by `min_sel`: 00 gives 5, 01 gives 17, and 10 or 11 gives 27. The flag changes at no other time.
- R7: `byte_ready` is high only in the single cycle after start or after a gap ends. A byte accepted at a clock edge makes `sclk` fall at that same edge. `byte_ready` stays low while a byte is shifting.
- R8: `busy` rises one cycle after `start`. It falls after the handshake cycle in which no byte is valid. A start with no byte pending gives exactly one busy cycle and no clock activity.
- R9: After reset, `sclk`=1, `sdo`=1, `busy`=0, `byte_ready`=0, `div_err`=0 and `gap_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: [7:5] divider code, [4:0] gap code |
| min_sel | input | 2 | Operating mode for the minimum-gap check |
| start | input | 1 | Begin a burst when idle |
| byte_valid | input | 1 | Source has a byte |
| byte_data | input | 8 | Byte to send |
| byte_ready | output | 1 | Block takes the byte this cycle |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, LSB first |
| busy | output | 1 | Burst in progress |
| div_err | output | 1 | Reserved divider code written |
| gap_err | output | 1 | Programmed gap below the mode minimum |

## Verification
Both flags are registered at the control write, so the bench reads them at the falling edge just after the write edge. A start makes `byte_ready` visible at the next falling edge, and a byte accepted at a rising edge pulls `sclk` low from that edge. A bus monitor samples `sclk` and `sdo` at every falling system-clock edge and counts the low and high run lengths in whole system clocks. Each run is compared with N/2, and the run between bytes is compared with N/2+(k+2)*N+1. These widths are computed from the control word alone, and the bench waits for `busy` to drop before it judges a burst.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HAND  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } sbt_state_t;

  localparam int unsigned NUM_LEGAL_DIV = 3;
endpackage

// File: rtl/sbt_cfg.sv
module sbt_cfg #(
  parameter int GAP_W      = 5,
  parameter int DIV_W      = 3,
  parameter int MIN_BASIC  = 5,
  parameter int MIN_ASSIST = 17,
  parameter int MIN_GRAD   = 27
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [DIV_W+GAP_W-1:0] wdata,
  input  logic [1:0]             min_sel,
  output logic [1:0]             div_sel,
  output logic [GAP_W-1:0]       gap_code,
  output logic                   div_err,
  output logic                   gap_err
);
  localparam int CFG_W  = DIV_W + GAP_W;
  localparam int GCLK_W = GAP_W + 6;

  logic [DIV_W-1:0]  raw_div;
  logic              legal;
  logic [1:0]        sel_n;
  logic [GCLK_W-1:0] gap_clks;
  logic [GCLK_W-1:0] min_clks;

  assign raw_div = wdata[CFG_W-1:GAP_W];
  assign legal   = (raw_div < DIV_W'(sbt_pkg::NUM_LEGAL_DIV));
  assign sel_n   = legal ? raw_div[1:0] : 2'd0;

  // gap in system clocks: (k + 2) * N, with N = 4 << sel
  assign gap_clks = (GCLK_W'(wdata[GAP_W-1:0]) + GCLK_W'(2)) << (3'(sel_n) + 3'd2);

  always_comb begin
    case (min_sel)
      2'd0:    min_clks = GCLK_W'(MIN_BASIC);
      2'd1:    min_clks = GCLK_W'(MIN_ASSIST);
      default: min_clks = GCLK_W'(MIN_GRAD);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_sel  <= 2'd0;
      gap_code <= '0;
      div_err  <= 1'b0;
      gap_err  <= 1'b0;
    end else if (we) begin
      div_sel  <= sel_n;
      gap_code <= wdata[GAP_W-1:0];
      div_err  <= ~legal;
      gap_err  <= (gap_clks < min_clks);
    end
  end
endmodule

// File: rtl/sbt_tick.sv
module sbt_tick #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       half,
  output logic       full
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] hlim;

  always_comb begin
    case (div_sel)
      2'd0:    begin lim = CNT_W'(3);  hlim = CNT_W'(1); end
      2'd1:    begin lim = CNT_W'(7);  hlim = CNT_W'(3); end
      default: begin lim = CNT_W'(15); hlim = CNT_W'(7); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end

  assign half = run && (cnt == hlim);
  assign full = run && (cnt == lim);
endmodule

// File: rtl/sbt_seq.sv
module sbt_seq #(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [GAP_W-1:0]  gap_code,
  input  logic              half,
  input  logic              full,
  output logic              run,
  output logic              byte_ready,
  output logic              busy,
  output logic              sclk,
  output logic              sdo
);
  import sbt_pkg::*;
  localparam int BIT_W = $clog2(DATA_W);

  sbt_state_t        state;
  logic [DATA_W-1:0] sh;
  logic [BIT_W-1:0]  bitc;
  logic [GAP_W:0]    gcnt;
  logic [GAP_W:0]    glast;

  assign glast      = {1'b0, gap_code} + (GAP_W+1)'(1);
  assign run        = (state == ST_SHIFT) || (state == ST_GAP);
  assign byte_ready = (state == ST_HAND);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      sclk  <= 1'b1;
      sdo   <= 1'b1;
      sh    <= '0;
      bitc  <= '0;
      gcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_HAND;
        ST_HAND: begin
          if (byte_valid) begin
            sh    <= byte_data;
            sdo   <= byte_data[0];
            sclk  <= 1'b0;
            bitc  <= '0;
            state <= ST_SHIFT;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (half) sclk <= 1'b1;
          if (full) begin
            if (bitc == BIT_W'(DATA_W-1)) begin
              gcnt  <= '0;
              state <= ST_GAP;
            end else begin
              bitc <= bitc + BIT_W'(1);
              sh   <= sh >> 1;
              sdo  <= sh[1];
              sclk <= 1'b0;
            end
          end
        end
        ST_GAP: begin
          if (full) begin
            if (gcnt == glast) state <= ST_HAND;
            else gcnt <= gcnt + (GAP_W+1)'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sync_burst_tx.sv
module sync_burst_tx #(
  parameter int DATA_W     = 8,
  parameter int GAP_W      = 5,
  parameter int DIV_W      = 3,
  parameter int CNT_W      = 4,
  parameter int MIN_BASIC  = 5,
  parameter int MIN_ASSIST = 17,
  parameter int MIN_GRAD   = 27
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [DIV_W+GAP_W-1:0] cfg_wdata,
  input  logic [1:0]             min_sel,
  input  logic                   start,
  input  logic                   byte_valid,
  input  logic [DATA_W-1:0]      byte_data,
  output logic                   byte_ready,
  output logic                   sclk,
  output logic                   sdo,
  output logic                   busy,
  output logic                   div_err,
  output logic                   gap_err
);
  logic [1:0]       div_sel;
  logic [GAP_W-1:0] gap_code;
  logic             run, half, full;

  sbt_cfg #(
    .GAP_W(GAP_W), .DIV_W(DIV_W), .MIN_BASIC(MIN_BASIC),
    .MIN_ASSIST(MIN_ASSIST), .MIN_GRAD(MIN_GRAD)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .min_sel(min_sel),
    .div_sel(div_sel), .gap_code(gap_code), .div_err(div_err), .gap_err(gap_err)
  );

  sbt_tick #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .div_sel(div_sel), .half(half), .full(full)
  );

  sbt_seq #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .gap_code(gap_code), .half(half), .full(full),
    .run(run), .byte_ready(byte_ready), .busy(busy), .sclk(sclk), .sdo(sdo)
  );
endmodule

// File: rtl/sync_burst_tx_chk.sv
module sync_burst_tx_chk #(
  parameter int CFG_W = 8,
  parameter int GAP_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic             sclk,
  input logic             sdo,
  input logic             busy,
  input logic             div_err,
  input logic             gap_err
);
  a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk);

  a_r7_ready_busy: assert property (@(posedge clk) disable iff (rst)
    byte_ready |-> busy);

  a_r7_accept_fall: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_ready) |=> !sclk);

  a_r3_sdo_hold: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo));

  a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> ($stable(gap_err) && $stable(div_err)));

  a_r2_div_flag: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (div_err == ($past(cfg_wdata[CFG_W-1:GAP_W]) > 3'd2)));
endmodule

bind sync_burst_tx sync_burst_tx_chk #(.CFG_W(8), .GAP_W(5)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .byte_valid(byte_valid), .byte_ready(byte_ready), .sclk(sclk), .sdo(sdo),
  .busy(busy), .div_err(div_err), .gap_err(gap_err)
);

// File: tb/sync_burst_tx_test.sv
module sync_burst_tx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] min_sel = '0;
  logic       start = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       byte_ready, sclk, sdo, busy, div_err, gap_err;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  sync_burst_tx uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .min_sel(min_sel), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .sclk(sclk), .sdo(sdo),
    .busy(busy), .div_err(div_err), .gap_err(gap_err)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // {cfg, min_sel, byte0, byte1, exp gap_err, exp div_err}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {8'h00, 2'd0, 8'hA5, 8'h3C, 1'b0, 1'b0},
    {8'h23, 2'd1, 8'h01, 8'h80, 1'b0, 1'b0},
    {8'h02, 2'd1, 8'hFF, 8'h00, 1'b1, 1'b0},
    {8'h03, 2'd1, 8'h5A, 8'hC3, 1'b0, 1'b0},
    {8'h40, 2'd2, 8'h96, 8'h69, 1'b0, 1'b0},
    {8'h21, 2'd2, 8'h0F, 8'hF0, 1'b1, 1'b0},
    {8'h22, 2'd2, 8'h81, 8'h7E, 1'b0, 1'b0},
    {8'h04, 2'd3, 8'h33, 8'hCC, 1'b1, 1'b0},
    {8'h61, 2'd0, 8'hE7, 8'h18, 1'b0, 1'b1},
    {8'hFF, 2'd2, 8'h12, 8'h48, 1'b0, 1'b1},
    {8'h5F, 2'd0, 8'hAA, 8'h55, 1'b0, 1'b0}
  };

  // bus monitor, sampled at falling system-clock edges
  logic       mon_clr = 1'b0;
  int         exp_half = 2;
  logic       prev_s = 1'b1;
  int         lowrun = 0, highrun = 0, nbits = 0, nbytes = 0, gap_run = 0;
  logic       width_bad = 1'b0;
  logic [7:0] rxsh = '0;
  logic [7:0] rxb [4];

  always @(negedge clk) begin
    if (mon_clr) begin
      lowrun = 0; highrun = 0; nbits = 0; nbytes = 0; gap_run = 0;
      width_bad = 1'b0; prev_s = sclk;
    end else begin
      if (sclk && !prev_s) begin
        if (lowrun != exp_half) width_bad = 1'b1;
        rxsh = {sdo, rxsh[7:1]};
        nbits++;
        if (nbits == 8) begin
          if (nbytes < 4) rxb[nbytes] = rxsh;
          nbytes++;
          nbits = 0;
        end
        highrun = 1;
      end else if (sclk) begin
        highrun++;
      end
      if (!sclk && prev_s) begin
        if (nbits == 0 && nbytes > 0) gap_run = highrun;
        else if (nbits != 0 && highrun != exp_half) width_bad = 1'b1;
        lowrun = 1;
      end else if (!sclk) begin
        lowrun++;
      end
      prev_s = sclk;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    logic [7:0] cfg = VEC[i][27:20];
    logic [1:0] ms  = VEC[i][19:18];
    logic [7:0] d0  = VEC[i][17:10];
    logic [7:0] d1  = VEC[i][9:2];
    int n = (cfg[7:5] == 3'd1) ? 8 : (cfg[7:5] == 3'd2) ? 16 : 4;
    int k = int'(cfg[4:0]);
    exp_half = n / 2;
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    cfg_we = 1'b1; cfg_wdata = cfg; min_sel = ms;
    @(negedge clk);
    cfg_we = 1'b0;
    chk($sformatf("R6 gap_err vec%0d", i), int'(gap_err), int'(VEC[i][1]));
    chk($sformatf("R2 div_err vec%0d", i), int'(div_err), int'(VEC[i][0]));
    byte_valid = 1'b1; byte_data = d0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 2000 && !byte_ready; t++) @(negedge clk);
    @(negedge clk);
    chk($sformatf("R7 ready low in shift vec%0d", i), int'(byte_ready), 0);
    byte_data = d1;
    for (int t = 0; t < 2000 && !byte_ready; t++) @(negedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
    for (int t = 0; t < 3000 && busy; t++) @(negedge clk);
    chk($sformatf("R8 busy end vec%0d", i), int'(busy), 0);
    chk($sformatf("R3 byte count vec%0d", i), nbytes, 2);
    chk($sformatf("R3 byte0 vec%0d", i), int'(rxb[0]), int'(d0));
    chk($sformatf("R3 byte1 vec%0d", i), int'(rxb[1]), int'(d1));
    chk($sformatf("R1 bit widths vec%0d", i), int'(width_bad), 0);
    chk($sformatf("R4 gap run vec%0d", i), gap_run, n / 2 + (k + 2) * n + 1);
    chk($sformatf("R5 sclk idle vec%0d", i), int'(sclk), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 sclk", int'(sclk), 1);
    chk("R9 sdo", int'(sdo), 1);
    chk("R9 busy", int'(busy), 0);
    chk("R9 ready", int'(byte_ready), 0);
    chk("R9 div_err", int'(div_err), 0);
    chk("R9 gap_err", int'(gap_err), 0);

    // R8: start with no byte pending
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", int'(busy), 1);
    chk("R7 ready after start", int'(byte_ready), 1);
    @(negedge clk);
    chk("R8 busy drops with no byte", int'(busy), 0);
    chk("R5 no toggle with no byte", int'(sclk), 1);
    repeat (10) @(negedge clk);
    chk("R5 idle stays high", int'(sclk), 1);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R6: flags move only on a write
    min_sel = 2'd2;
    repeat (5) @(negedge clk);
    chk("R6 flag held without write", int'(gap_err), 0);
    cfg_we = 1'b1; cfg_wdata = 8'h00;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R6 flag set on write", int'(gap_err), 1);
    min_sel = 2'd0;
    repeat (5) @(negedge clk);
    chk("R6 flag kept after mode change", int'(gap_err), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule